// File: doc/BRIEF.md
# USB OUT Endpoint Receive Peripheral

This block takes OUT data packets from a USB device core and places them in a byte FIFO that a CPU reads through a small register bus. The CPU chooses which endpoints may receive by setting per-endpoint ready ("prime") flags, and it arms reception with a single enable bit. That bit clears itself after one packet has been stored, so each arm lets exactly one packet through. Per-endpoint halt ("stall") flags and per-endpoint data-toggle bits are reached through the same endpoint-select register. Every OUT packet gets a handshake code back: ACK, NAK or STALL. A packet that fails its CRC gets no handshake and leaves no trace in the FIFO.

A state machine follows each transaction through three states. IDLE waits for a token. RX takes in the data bytes. HS presents the handshake for one cycle and commits the packet. The transitions are:

- TOKEN (IDLE to RX): the verdict and the endpoint are latched.
- RETOKEN (RX to RX): the partial packet is rolled back and the verdict is taken again.
- BADCRC (RX to IDLE): rollback, with no handshake.
- END (RX to HS): the handshake code and the keep decision are latched.
- DONE (HS to IDLE): the packet is committed when it is kept.

Bytes are written into the FIFO as they arrive. They become visible to the CPU only at commit, and a rollback discards them.

Top module: `usb_out_rx`

## Requirements
- R1: After reset, the have flag, the pend flag, irq, the enable bit and the device address all read 0.
- R2: The address register (offset 9) reads back what was written. A pulse on usb_bus_reset returns it to 0.
- R3: Every OUT packet with a good CRC gets exactly one single-cycle hs_valid pulse, in the cycle after rx_end. The codes are 1 = ACK, 2 = NAK, 3 = STALL. A packet for an endpoint that has no prime flag is NAKed and stores nothing.
- R4: A packet is stored and ACKed only when four conditions hold: tok_addr equals the address register, the endpoint is primed, enable is 1, and the endpoint is not stalled. Its bytes then come out of the data register (offset 0) in arrival order, one per read. data_ep (offset 1) gives its endpoint, and pend (offset 8) and irq go to 1.
- R5: The enable bit (offset 4, bit 0) clears when a packet is stored. A second packet is NAKed until enable is written to 1 again.
- R6: Writing bit 0 to the prime register (offset 5) sets or clears the prime flag of the endpoint named in the select register (offset 3). A prime flag survives a stored packet.
- R7: Writing bit 0 to the stall register (offset 6) sets or clears the stall flag of the selected endpoint. The flag persists when the selection changes. A stalled, address-matched endpoint is answered with STALL, and other endpoints are unaffected.
- R8: A packet whose tok_addr differs from the address register is NAKed and stores nothing.
- R9: A packet ending with rx_crc_ok = 0 produces no handshake. Its bytes are discarded, enable stays 1 and pend stays 0.
- R10: An accepted packet whose rx_pid differs from the expected toggle is ACKed but discarded. The toggle, enable and pend are unchanged.
- R11: The pid register (offset 10) holds the toggle of the selected endpoint. It is writable per endpoint, and it inverts after each stored packet on that endpoint.
- R12: Any write to the flush register (offset 2) empties the FIFO, so have (offset 7) reads 0.
- R13: Writing 1 to bit 0 of offset 8 clears pend. irq always equals pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_bus_reset | input | 1 | Bus reset seen on the USB side |
| tok_valid | input | 1 | OUT token strobe |
| tok_addr | input | 8 | Device address carried by the token |
| tok_ep | input | 4 | Endpoint carried by the token |
| rx_valid | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_end | input | 1 | End of data packet strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| rx_pid | input | 1 | Data PID toggle (0 = DATA0), valid with rx_end |
| hs_valid | output | 1 | Handshake request strobe |
| hs_code | output | 2 | Handshake code: 1 ACK, 2 NAK, 3 STALL |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at offset 0) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Packet-received interrupt |

## Verification
Packets are sent to an endpoint that is not primed, to a primed and armed endpoint, to the same endpoint again once enable has cleared, to a stalled endpoint, and with a wrong device address. Each one yields a different handshake code or a different FIFO state, which separates the verdict priorities. A packet with a bad CRC, followed by a good one, shows whether the rollback leaves exactly the second packet's bytes. A duplicate packet with a stale toggle must be ACKed while have, pend, enable and pid all stay as they were. Toggle and stall flags are read back on several endpoints to show that each is held per endpoint.

// File: rtl/usb_out_rx_pkg.sv
`timescale 1ns/1ps
package usb_out_rx_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_HS   = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        V_NAK   = 2'd0,
        V_STALL = 2'd1,
        V_TAKE  = 2'd2
    } verdict_e;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] REG_DATA    = 4'd0;
    localparam logic [REG_AW-1:0] REG_DATA_EP = 4'd1;
    localparam logic [REG_AW-1:0] REG_FLUSH   = 4'd2;
    localparam logic [REG_AW-1:0] REG_EPSEL   = 4'd3;
    localparam logic [REG_AW-1:0] REG_ENABLE  = 4'd4;
    localparam logic [REG_AW-1:0] REG_PRIME   = 4'd5;
    localparam logic [REG_AW-1:0] REG_STALL   = 4'd6;
    localparam logic [REG_AW-1:0] REG_HAVE    = 4'd7;
    localparam logic [REG_AW-1:0] REG_PEND    = 4'd8;
    localparam logic [REG_AW-1:0] REG_ADDR    = 4'd9;
    localparam logic [REG_AW-1:0] REG_PID     = 4'd10;

endpackage

// File: rtl/out_rx_fifo.sv
`timescale 1ns/1ps
// Byte FIFO with a tentative write pointer: writes become readable
// only after commit, and rollback rewinds to the last commit point.
module out_rx_fifo #(
    parameter int DEPTH = 512,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          rollback,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          have
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic          full;
    logic [PW-1:0] level;

    assign full  = (wr_ptr - rd_ptr) == DEPTH_P;
    assign level = cm_ptr - rd_ptr;
    assign have  = level != '0;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full && !flush) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (rollback) begin
                wr_ptr <= cm_ptr;
            end else begin
                if (wr_en && !full) wr_ptr <= wr_ptr + 1'b1;
                if (commit)         cm_ptr <= wr_ptr;
            end
            if (rd_en && have) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/out_ep_flags.sv
`timescale 1ns/1ps
// Per-endpoint prime, stall and data-toggle bits.
module out_ep_flags #(
    parameter int EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EP_W-1:0] sel_ep,
    input  logic            wr_prime,
    input  logic            wr_stall,
    input  logic            wr_pid,
    input  logic            wbit,
    input  logic [EP_W-1:0] look_ep,
    input  logic [EP_W-1:0] pkt_ep,
    input  logic            flip,
    output logic            sel_prime,
    output logic            sel_stall,
    output logic            sel_pid,
    output logic            look_prime,
    output logic            look_stall,
    output logic            pkt_pid
);
    localparam int NUM_EP = 1 << EP_W;

    logic [NUM_EP-1:0] prime_v, stall_v, tog_v;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic p_q, s_q, t_q;
        logic hit_sel, hit_pkt;

        assign hit_sel = sel_ep == EP_W'(e);
        assign hit_pkt = pkt_ep == EP_W'(e);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_q <= 1'b0;
                s_q <= 1'b0;
                t_q <= 1'b0;
            end else begin
                if (wr_prime && hit_sel) p_q <= wbit;
                if (wr_stall && hit_sel) s_q <= wbit;
                if (wr_pid && hit_sel)   t_q <= wbit;
                else if (flip && hit_pkt) t_q <= ~t_q;
            end
        end

        assign prime_v[e] = p_q;
        assign stall_v[e] = s_q;
        assign tog_v[e]   = t_q;
    end

    assign sel_prime  = prime_v[sel_ep];
    assign sel_stall  = stall_v[sel_ep];
    assign sel_pid    = tog_v[sel_ep];
    assign look_prime = prime_v[look_ep];
    assign look_stall = stall_v[look_ep];
    assign pkt_pid    = tog_v[pkt_ep];
endmodule

// File: rtl/out_rx_fsm.sv
`timescale 1ns/1ps
// Transaction sequencer: IDLE -> RX -> HS -> IDLE.
module out_rx_fsm
    import usb_out_rx_pkg::*;
#(
    parameter int EP_W = 4,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [AW-1:0]   tok_addr,
    input  logic [EP_W-1:0] tok_ep,
    input  logic [AW-1:0]   dev_addr,
    input  logic            look_prime,
    input  logic            look_stall,
    input  logic            enable,
    input  logic            rx_valid,
    input  logic            rx_end,
    input  logic            rx_crc_ok,
    input  logic            rx_pid,
    input  logic            pkt_pid,
    output logic            fifo_wr,
    output logic            fifo_commit,
    output logic            fifo_rollback,
    output logic            hs_valid,
    output hs_code_e        hs_code,
    output logic            store_done,
    output logic [EP_W-1:0] cur_ep
);
    rx_state_e       state_q, state_d;
    verdict_e        verdict_q, verdict_d, tok_verdict;
    hs_code_e        hs_q, hs_d;
    logic            store_q, store_d;
    logic [EP_W-1:0] ep_q, ep_d;
    logic            addr_ok, keep_pkt;

    assign addr_ok  = tok_addr == dev_addr;
    assign keep_pkt = rx_crc_ok && (verdict_q == V_TAKE) && (rx_pid == pkt_pid);
    assign cur_ep   = ep_q;

    always_comb begin
        if (addr_ok && look_stall)                 tok_verdict = V_STALL;
        else if (addr_ok && look_prime && enable)  tok_verdict = V_TAKE;
        else                                       tok_verdict = V_NAK;
    end

    // next-state logic
    always_comb begin
        state_d   = state_q;
        verdict_d = verdict_q;
        ep_d      = ep_q;
        hs_d      = hs_q;
        store_d   = store_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_valid) begin            // TOKEN
                    state_d   = ST_RX;
                    verdict_d = tok_verdict;
                    ep_d      = tok_ep;
                end
            end
            ST_RX: begin
                if (tok_valid) begin            // RETOKEN
                    verdict_d = tok_verdict;
                    ep_d      = tok_ep;
                end else if (rx_end) begin
                    if (!rx_crc_ok) begin       // BADCRC
                        state_d = ST_IDLE;
                    end else begin              // END
                        state_d = ST_HS;
                        store_d = keep_pkt;
                        unique case (verdict_q)
                            V_STALL: hs_d = HS_STALL;
                            V_TAKE:  hs_d = HS_ACK;
                            default: hs_d = HS_NAK;
                        endcase
                    end
                end
            end
            ST_HS: begin                        // DONE
                state_d = ST_IDLE;
                store_d = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= V_NAK;
            ep_q      <= '0;
            hs_q      <= HS_NONE;
            store_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            ep_q      <= ep_d;
            hs_q      <= hs_d;
            store_q   <= store_d;
        end
    end

    // outputs
    always_comb begin
        fifo_wr       = 1'b0;
        fifo_rollback = 1'b0;
        fifo_commit   = 1'b0;
        store_done    = 1'b0;
        hs_valid      = 1'b0;
        hs_code       = HS_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_RX: begin
                fifo_wr       = !tok_valid && rx_valid && (verdict_q == V_TAKE);
                fifo_rollback = tok_valid || (rx_end && !keep_pkt);
            end
            ST_HS: begin
                hs_valid    = 1'b1;
                hs_code     = hs_q;
                fifo_commit = store_q;
                store_done  = store_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_out_rx.sv
`timescale 1ns/1ps
module usb_out_rx
    import usb_out_rx_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_bus_reset,
    input  logic              tok_valid,
    input  logic [DATA_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    input  logic              rx_pid,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [EP_W-1:0]   epsel_q, data_ep_q, cur_ep;
    logic              enable_q, pend_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] fifo_q;
    logic              have_w;
    logic              fifo_wr, fifo_commit, fifo_rollback, store_done;
    logic              sel_prime, sel_stall, sel_pid, look_prime, look_stall, pkt_pid;
    hs_code_e          hs_code_w;
    logic              wr_flush, wr_prime, wr_stall, wr_pid, rd_pop;

    assign wr_flush = reg_wr && (reg_addr == REG_FLUSH);
    assign wr_prime = reg_wr && (reg_addr == REG_PRIME);
    assign wr_stall = reg_wr && (reg_addr == REG_STALL);
    assign wr_pid   = reg_wr && (reg_addr == REG_PID);
    assign rd_pop   = reg_rd && (reg_addr == REG_DATA);

    out_rx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (wr_flush),
        .wr_en    (fifo_wr),
        .wr_data  (rx_data),
        .commit   (fifo_commit),
        .rollback (fifo_rollback),
        .rd_en    (rd_pop),
        .rd_data  (fifo_q),
        .have     (have_w)
    );

    out_ep_flags #(.EP_W(EP_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_ep     (epsel_q),
        .wr_prime   (wr_prime),
        .wr_stall   (wr_stall),
        .wr_pid     (wr_pid),
        .wbit       (reg_wdata[0]),
        .look_ep    (tok_ep),
        .pkt_ep     (cur_ep),
        .flip       (store_done),
        .sel_prime  (sel_prime),
        .sel_stall  (sel_stall),
        .sel_pid    (sel_pid),
        .look_prime (look_prime),
        .look_stall (look_stall),
        .pkt_pid    (pkt_pid)
    );

    out_rx_fsm #(.EP_W(EP_W), .AW(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .tok_addr      (tok_addr),
        .tok_ep        (tok_ep),
        .dev_addr      (addr_q),
        .look_prime    (look_prime),
        .look_stall    (look_stall),
        .enable        (enable_q),
        .rx_valid      (rx_valid),
        .rx_end        (rx_end),
        .rx_crc_ok     (rx_crc_ok),
        .rx_pid        (rx_pid),
        .pkt_pid       (pkt_pid),
        .fifo_wr       (fifo_wr),
        .fifo_commit   (fifo_commit),
        .fifo_rollback (fifo_rollback),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code_w),
        .store_done    (store_done),
        .cur_ep        (cur_ep)
    );

    assign hs_code = hs_code_w;
    assign irq     = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epsel_q   <= '0;
            data_ep_q <= '0;
            enable_q  <= 1'b0;
            pend_q    <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (reg_wr && reg_addr == REG_EPSEL) epsel_q <= reg_wdata[EP_W-1:0];

            if (store_done) data_ep_q <= cur_ep;

            if (store_done) enable_q <= 1'b0;
            if (reg_wr && reg_addr == REG_ENABLE) enable_q <= reg_wdata[0];

            if (store_done) pend_q <= 1'b1;
            else if (reg_wr && reg_addr == REG_PEND && reg_wdata[0]) pend_q <= 1'b0;

            if (usb_bus_reset) addr_q <= '0;
            else if (reg_wr && reg_addr == REG_ADDR) addr_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_DATA:    reg_rdata = have_w ? fifo_q : '0;
            REG_DATA_EP: reg_rdata = DATA_W'(data_ep_q);
            REG_EPSEL:   reg_rdata = DATA_W'(epsel_q);
            REG_ENABLE:  reg_rdata = DATA_W'(enable_q);
            REG_PRIME:   reg_rdata = DATA_W'(sel_prime);
            REG_STALL:   reg_rdata = DATA_W'(sel_stall);
            REG_HAVE:    reg_rdata = DATA_W'(have_w);
            REG_PEND:    reg_rdata = DATA_W'(pend_q);
            REG_ADDR:    reg_rdata = addr_q;
            REG_PID:     reg_rdata = DATA_W'(sel_pid);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_out_rx_chk.sv
`timescale 1ns/1ps
module usb_out_rx_chk
    import usb_out_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              usb_bus_reset,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic              irq,
    input logic              have,
    input logic              enable,
    input logic [7:0]        dev_addr
);
    p_hs_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    p_hs_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> hs_code != 2'd0);

    p_irq_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hs_valid) && $past(hs_code) == 2'd1));

    p_enable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(reg_wr && reg_addr == REG_ENABLE)) |-> !enable);

    p_addr_bus_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        usb_bus_reset |=> dev_addr == 8'd0);

    p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_FLUSH) |=> !have);
endmodule

bind usb_out_rx usb_out_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .usb_bus_reset (usb_bus_reset),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .irq           (irq),
    .have          (have_w),
    .enable        (enable_q),
    .dev_addr      (addr_q)
);

// File: tb/usb_out_rx_test.sv
`timescale 1ns/1ps
module usb_out_rx_test;
    localparam logic [3:0] A_DATA = 4'd0, A_DEP = 4'd1, A_FLUSH = 4'd2, A_SEL = 4'd3,
                           A_EN = 4'd4, A_PRIME = 4'd5, A_STALL = 4'd6, A_HAVE = 4'd7,
                           A_PEND = 4'd8, A_ADDR = 4'd9, A_PID = 4'd10;
    localparam logic [1:0] ACK = 2'd1, NAK = 2'd2, STL = 2'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0, usb_bus_reset = 1'b0;
    logic       tok_valid = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0, rx_pid = 1'b0;
    logic [7:0] tok_addr = '0, rx_data = '0, reg_wdata = '0;
    logic [3:0] tok_ep = '0, reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic       hs_valid, irq;
    logic [1:0] hs_code;
    logic [7:0] reg_rdata;

    usb_out_rx uut (
        .clk(clk), .rst_n(rst_n), .usb_bus_reset(usb_bus_reset),
        .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_crc_ok(rx_crc_ok), .rx_pid(rx_pid),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] a, input logic [3:0] ep, input logic pid, input int n,
                        input logic [7:0] seed, input logic crc, output logic v, output logic [1:0] c);
        tok_valid = 1'b1; tok_addr = a; tok_ep = ep;
        @(negedge clk);
        tok_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1; rx_data = seed + 8'(k);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_end = 1'b1; rx_crc_ok = crc; rx_pid = pid;
        @(negedge clk);
        rx_end = 1'b0;
        v = hs_valid; c = hs_code;
        @(negedge clk);
    endtask

    task automatic drain(input string req, input int n, input logic [7:0] seed);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            rd(A_DATA, d);
            check(req, "data byte", d, seed + 8'(k));
        end
        rd(A_HAVE, d);
        check(req, "have after drain", d, 8'd0);
    endtask

    task automatic t_reset_r1;
        logic [7:0] d;
        rd(A_HAVE, d); check("R1", "have", d, 0);
        rd(A_PEND, d); check("R1", "pend", d, 0);
        check("R1", "irq", irq, 0);
        rd(A_EN, d);   check("R1", "enable", d, 0);
        rd(A_ADDR, d); check("R1", "address", d, 0);
    endtask

    task automatic t_address_r2;
        logic [7:0] d;
        wr(A_ADDR, 8'h05); rd(A_ADDR, d); check("R2", "address write", d, 8'h05);
        usb_bus_reset = 1'b1; @(negedge clk); usb_bus_reset = 1'b0;
        rd(A_ADDR, d); check("R2", "address after bus reset", d, 0);
        wr(A_ADDR, 8'h05);
    endtask

    task automatic t_unprimed_r3;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_EN, 1); wr(A_SEL, 2);
        send(8'h05, 4'd2, 1'b0, 3, 8'h30, 1'b1, v, c);
        check("R3", "hs_valid", v, 1); check("R3", "NAK code", c, NAK);
        rd(A_HAVE, d); check("R3", "nothing stored", d, 0);
        check("R3", "irq", irq, 0);
    endtask

    task automatic t_capture_r4;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_PRIME, 1);
        send(8'h05, 4'd2, 1'b0, 4, 8'h10, 1'b1, v, c);
        check("R4", "hs_valid", v, 1); check("R4", "ACK code", c, ACK);
        check("R4", "irq", irq, 1);
        rd(A_HAVE, d); check("R4", "have", d, 1);
        rd(A_DEP, d);  check("R4", "data_ep", d, 2);
        drain("R4", 4, 8'h10);
    endtask

    task automatic t_oneshot_r5;
        logic v; logic [1:0] c; logic [7:0] d;
        rd(A_EN, d); check("R5", "enable cleared", d, 0);
        send(8'h05, 4'd2, 1'b1, 2, 8'h60, 1'b1, v, c);
        check("R5", "second packet NAK", c, NAK);
        rd(A_HAVE, d); check("R5", "nothing stored", d, 0);
    endtask

    task automatic t_prime_persist_r6;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_PEND, 1); check("R13", "irq after pend clear", irq, 0);
        rd(A_PID, d); check("R11", "toggle flipped", d, 1);
        rd(A_PRIME, d); check("R6", "prime persists", d, 1);
        wr(A_EN, 1);
        send(8'h05, 4'd2, 1'b1, 2, 8'h20, 1'b1, v, c);
        check("R6", "ACK without re-prime", c, ACK);
        drain("R6", 2, 8'h20);
        rd(A_PID, d); check("R11", "toggle flipped again", d, 0);
        wr(A_PEND, 1);
    endtask

    task automatic t_stall_r7;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_SEL, 3); wr(A_STALL, 1);
        wr(A_SEL, 4); wr(A_PRIME, 1); wr(A_EN, 1);
        send(8'h05, 4'd3, 1'b0, 2, 8'h70, 1'b1, v, c);
        check("R7", "STALL code", c, STL);
        send(8'h05, 4'd4, 1'b0, 3, 8'h80, 1'b1, v, c);
        check("R7", "other endpoint ACK", c, ACK);
        wr(A_SEL, 3); rd(A_STALL, d); check("R7", "stall persists", d, 1);
        wr(A_SEL, 4); rd(A_STALL, d); check("R7", "ep4 not stalled", d, 0);
        rd(A_HAVE, d); check("R12", "have before flush", d, 1);
        wr(A_FLUSH, 1);
        rd(A_HAVE, d); check("R12", "have after flush", d, 0);
        wr(A_PEND, 1);
    endtask

    task automatic t_addr_mismatch_r8;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_EN, 1);
        send(8'h06, 4'd4, 1'b1, 2, 8'h90, 1'b1, v, c);
        check("R8", "NAK code", c, NAK);
        rd(A_HAVE, d); check("R8", "nothing stored", d, 0);
    endtask

    task automatic t_crc_r9;
        logic v; logic [1:0] c; logic [7:0] d;
        send(8'h05, 4'd4, 1'b1, 3, 8'h40, 1'b0, v, c);
        check("R9", "no handshake", v, 0);
        rd(A_HAVE, d); check("R9", "nothing stored", d, 0);
        rd(A_EN, d);   check("R9", "enable kept", d, 1);
        rd(A_PEND, d); check("R9", "pend kept", d, 0);
        send(8'h05, 4'd4, 1'b1, 2, 8'h50, 1'b1, v, c);
        check("R9", "retry ACK", c, ACK);
        drain("R9", 2, 8'h50);
        wr(A_PEND, 1);
    endtask

    task automatic t_dup_r10;
        logic v; logic [1:0] c; logic [7:0] d;
        wr(A_EN, 1);
        send(8'h05, 4'd4, 1'b1, 3, 8'hA0, 1'b1, v, c);
        check("R10", "duplicate ACK", c, ACK);
        rd(A_HAVE, d); check("R10", "discarded", d, 0);
        check("R10", "irq", irq, 0);
        rd(A_PID, d);  check("R10", "toggle unchanged", d, 0);
        rd(A_EN, d);   check("R10", "enable kept", d, 1);
    endtask

    task automatic t_pid_reg_r11;
        logic [7:0] d;
        wr(A_SEL, 6); wr(A_PID, 1); rd(A_PID, d); check("R11", "ep6 pid write", d, 1);
        wr(A_SEL, 4); rd(A_PID, d); check("R11", "ep4 pid independent", d, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_address_r2();
        t_unprimed_r3();
        t_capture_r4();
        t_oneshot_r5();
        t_prime_persist_r6();
        t_stall_r7();
        t_addr_mismatch_r8();
        t_crc_r9();
        t_dup_r10();
        t_pid_reg_r11();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule